// File: doc/BRIEF.md
# Checked Serial Write Frame Receiver

This block is the receive front end of a four-wire serial slave. While the active-low select line is held low, it takes one bit from the data input on every falling edge of the serial clock, most significant bit first. Because only the falling edge samples, the bus master may idle the clock low or high (modes 1 and 2). The serial clock, the select and the data input cross into the system clock domain through synchronizer stages. The block finds the clock edges there.

When the select line returns high, the block judges the captured frame. A full frame holds, from the top down, a slip bit, two device-address bits, a 5-bit register address, 16 data bits and an 8-bit CRC. A frame that passes every check becomes a one-cycle register write carrying the register address and data. A frame that fails a check is dropped. Depending on the failure, it may raise a single-cycle error pulse that a diagnostics block makes sticky. The CRC check is switched by an enable input that the register file drives. When the check is off, a 24-bit frame is valid and the CRC byte of a 32-bit frame is disregarded.

Several devices can share one bus and one select line. Each answers only to frames whose device-address bits equal its two strap pins.

Top module: `spi_frame_rx`

## Requirements
- R1: After reset, wr_valid_o, slip_err_o, crc_err_o, wr_addr_o and wr_data_o are all zero.
- R2: A bit is taken from sdi_i only on a falling edge of sclk_i while cs_ni is low. Bits enter MSB first. The clock may idle low or high between frames.
- R3: A valid 32-bit frame makes wr_valid_o high for exactly one cycle. The pulse comes on the third rising edge of clk_i after cs_ni rises. At the same time wr_addr_o carries frame bits 28:24 and wr_data_o carries bits 23:8.
- R4: Frame bit 31 must be the inverse of bit 30. If it is not, no write happens and slip_err_o pulses for one cycle.
- R5: When bits 30:29 (bit 30 is the MSB) differ from dev_addr_i, there is no write and no error pulse.
- R6: With crc_en_i high, the expected CRC byte is CRC-8 with polynomial 0x07, initial value 0 and no final inversion. It is taken over bits 31:8, MSB first, and compared with bits 7:0. On a mismatch in a frame with a correct slip bit, no write happens and crc_err_o pulses, whatever the address.
- R7: With crc_en_i low, a 24-bit frame (bits 31:8 only) is valid. A 32-bit frame is also valid, and its bits 7:0 are ignored.
- R8: A frame whose bit count at the select rise is not 32, and not 24 with the CRC off, is dropped with no write and no error pulse. With the CRC on, a 24-bit frame is dropped.
- R9: Clock edges while cs_ni is high have no effect. Every select fall restarts the bit count.
- R10: Each frame yields at most one of wr_valid_o, slip_err_o and crc_err_o. Every such pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the bus master |
| cs_ni | input | 1 | Frame select, active low |
| sdi_i | input | 1 | Serial data in |
| dev_addr_i | input | 2 | Strap pins giving this device's bus address |
| crc_en_i | input | 1 | CRC check enable, held high by the register file after reset |
| wr_valid_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 5 | Register address of the last accepted write |
| wr_data_o | output | 16 | Data of the last accepted write |
| slip_err_o | output | 1 | One-cycle slip-bit error pulse |
| crc_err_o | output | 1 | One-cycle CRC error pulse, used as the fault indication |

## Verification
Every verdict of the block (write strobe, slip error or CRC error) is registered. Its pulse lands on the third rising clock edge after cs_ni rises: two edges for the synchronizer and one for the result register. The bench raises the select on a falling clock edge, counts three rising edges, and samples at the following falling edge. It then samples once more, one cycle later, to confirm the pulse has ended. Serial bits are held for three system cycles on each clock level, and each frame is closed only after the last falling edge has passed the synchronizer.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int DEF_DEV_W    = 2;
  localparam int DEF_REG_W    = 5;
  localparam int DEF_DATA_W   = 16;
  localparam int DEF_CRC_W    = 8;
  localparam int DEF_SYNC_STG = 2;
  localparam logic [DEF_CRC_W-1:0] DEF_CRC_POLY = 8'h07;

  typedef enum logic [1:0] {
    VERDICT_DROP,
    VERDICT_WRITE,
    VERDICT_SLIP,
    VERDICT_CRC
  } verdict_e;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int FRAME_W = 32,
  parameter int CNT_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               sdi_i,
  output logic [FRAME_W-1:0] shreg_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               bit_stb_o,
  output logic               cs_fall_o,
  output logic               cs_rise_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic               sclk_q, cs_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  assign cs_fall_o = cs_q & ~cs_ni;
  assign cs_rise_o = ~cs_q & cs_ni;
  assign bit_stb_o = sclk_q & ~sclk_i & ~cs_ni & ~cs_fall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (cs_fall_o) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (bit_stb_o) begin
      shreg_q <= {shreg_q[FRAME_W-2:0], sdi_i};
      // saturate one past a full frame so over-length frames stay invalid
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign shreg_o = shreg_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/spi_rx_crc8.sv
module spi_rx_crc8 #(
  parameter int CRC_W = 8,
  parameter int HDR_W = 24,
  parameter int CNT_W = 6,
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             bit_stb_i,
  input  logic             bit_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb = crc_q[CRC_W-1] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
    end else if (clr_i) begin
      crc_q <= '0;
    end else if (bit_stb_i && (cnt_i < CNT_W'(HDR_W))) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/spi_rx_check.sv
module spi_rx_check
  import spi_rx_pkg::*;
#(
  parameter int DEV_W  = 2,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16,
  parameter int CRC_W  = 8,
  parameter int CNT_W  = 6
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cs_rise_i,
  input  logic [CNT_W-1:0]                cnt_i,
  input  logic [1+DEV_W+REG_W+DATA_W-1:0] hdr_i,
  input  logic [CRC_W-1:0]                rx_crc_i,
  input  logic [CRC_W-1:0]                calc_crc_i,
  input  logic                            crc_en_i,
  input  logic [DEV_W-1:0]                dev_addr_i,
  output logic                            wr_valid_o,
  output logic [REG_W-1:0]                wr_addr_o,
  output logic [DATA_W-1:0]               wr_data_o,
  output logic                            slip_err_o,
  output logic                            crc_err_o
);
  localparam int HDR_W   = 1 + DEV_W + REG_W + DATA_W;
  localparam int FRAME_W = HDR_W + CRC_W;

  logic     len_ok, slip_ok, dev_ok, crc_ok;
  verdict_e verdict;

  assign len_ok  = (cnt_i == CNT_W'(FRAME_W)) || ((cnt_i == CNT_W'(HDR_W)) && !crc_en_i);
  assign slip_ok = hdr_i[HDR_W-1] ^ hdr_i[HDR_W-2];
  assign dev_ok  = hdr_i[HDR_W-2 -: DEV_W] == dev_addr_i;
  assign crc_ok  = !crc_en_i || (calc_crc_i == rx_crc_i);

  // slip beats crc beats address: a corrupt frame is flagged on every device
  always_comb begin
    verdict = VERDICT_DROP;
    if (cs_rise_i && len_ok) begin
      if (!slip_ok)     verdict = VERDICT_SLIP;
      else if (!crc_ok) verdict = VERDICT_CRC;
      else if (dev_ok)  verdict = VERDICT_WRITE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      slip_err_o <= 1'b0;
      crc_err_o  <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= verdict == VERDICT_WRITE;
      slip_err_o <= verdict == VERDICT_SLIP;
      crc_err_o  <= verdict == VERDICT_CRC;
      if (verdict == VERDICT_WRITE) begin
        wr_addr_o <= hdr_i[DATA_W +: REG_W];
        wr_data_o <= hdr_i[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_rx_pkg::*;
#(
  parameter int DEV_W    = DEF_DEV_W,
  parameter int REG_W    = DEF_REG_W,
  parameter int DATA_W   = DEF_DATA_W,
  parameter int CRC_W    = DEF_CRC_W,
  parameter int SYNC_STG = DEF_SYNC_STG,
  parameter logic [CRC_W-1:0] CRC_POLY = DEF_CRC_POLY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic [DEV_W-1:0]  dev_addr_i,
  input  logic              crc_en_i,
  output logic              wr_valid_o,
  output logic [REG_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              slip_err_o,
  output logic              crc_err_o
);
  localparam int HDR_W   = 1 + DEV_W + REG_W + DATA_W;
  localparam int FRAME_W = HDR_W + CRC_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic               sclk_s, cs_s, sdi_s;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic               bit_stb, cs_fall, cs_rise;
  logic [CRC_W-1:0]   calc_crc;
  logic [HDR_W-1:0]   hdr;
  logic [DEV_W-1:0]   hdr_dev;

  spi_rx_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STG),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, sdi_i}),
    .q_o   ({sclk_s, cs_s, sdi_s})
  );

  spi_rx_shift #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_s),
    .cs_ni    (cs_s),
    .sdi_i    (sdi_s),
    .shreg_o  (shreg),
    .cnt_o    (bit_cnt),
    .bit_stb_o(bit_stb),
    .cs_fall_o(cs_fall),
    .cs_rise_o(cs_rise)
  );

  spi_rx_crc8 #(
    .CRC_W(CRC_W),
    .HDR_W(HDR_W),
    .CNT_W(CNT_W),
    .POLY (CRC_POLY)
  ) u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cs_fall),
    .bit_stb_i(bit_stb),
    .bit_i    (sdi_s),
    .cnt_i    (bit_cnt),
    .crc_o    (calc_crc)
  );

  // a short frame sits right-aligned in the shifter, a full one fills it
  assign hdr     = (bit_cnt == CNT_W'(FRAME_W)) ? shreg[FRAME_W-1 -: HDR_W] : shreg[HDR_W-1:0];
  assign hdr_dev = hdr[HDR_W-2 -: DEV_W];

  spi_rx_check #(
    .DEV_W (DEV_W),
    .REG_W (REG_W),
    .DATA_W(DATA_W),
    .CRC_W (CRC_W),
    .CNT_W (CNT_W)
  ) u_check (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_rise_i (cs_rise),
    .cnt_i     (bit_cnt),
    .hdr_i     (hdr),
    .rx_crc_i  (shreg[CRC_W-1:0]),
    .calc_crc_i(calc_crc),
    .crc_en_i  (crc_en_i),
    .dev_addr_i(dev_addr_i),
    .wr_valid_o(wr_valid_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .slip_err_o(slip_err_o),
    .crc_err_o (crc_err_o)
  );
endmodule

// File: rtl/spi_frame_rx_chk.sv
module spi_frame_rx_chk #(
  parameter int DEV_W   = 2,
  parameter int CNT_W   = 6,
  parameter int HDR_W   = 24,
  parameter int FRAME_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_rise_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [DEV_W-1:0] dev_i,
  input logic [DEV_W-1:0] dev_addr_i,
  input logic             crc_en_i,
  input logic             wr_valid_i,
  input logic             slip_err_i,
  input logic             crc_err_i
);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] SHORT = CNT_W'(HDR_W);

  logic any_pulse;
  assign any_pulse = wr_valid_i | slip_err_i | crc_err_i;

  p_one_verdict_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_valid_i, slip_err_i, crc_err_i}));

  p_single_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pulse |=> !any_pulse);

  p_after_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pulse |-> $past(cs_rise_i));

  p_dev_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |-> ($past(dev_i) == $past(dev_addr_i)));

  p_crc_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_i |-> $past(crc_en_i));

  p_length_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pulse |-> (($past(cnt_i) == FULL) || (($past(cnt_i) == SHORT) && !$past(crc_en_i))));
endmodule

bind spi_frame_rx spi_frame_rx_chk #(
  .DEV_W  (DEV_W),
  .CNT_W  (CNT_W),
  .HDR_W  (HDR_W),
  .FRAME_W(FRAME_W)
) u_frame_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_rise_i (cs_rise),
  .cnt_i     (bit_cnt),
  .dev_i     (hdr_dev),
  .dev_addr_i(dev_addr_i),
  .crc_en_i  (crc_en_i),
  .wr_valid_i(wr_valid_o),
  .slip_err_i(slip_err_o),
  .crc_err_i (crc_err_o)
);

// File: tb/spi_frame_rx_tb.sv
module spi_frame_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [1:0]  dev_addr = 2'b00;
  logic        crc_en = 1'b1;
  logic        wr_valid, slip_err, crc_err;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  spi_frame_rx u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sclk_i    (sclk),
    .cs_ni     (cs_n),
    .sdi_i     (sdi),
    .dev_addr_i(dev_addr),
    .crc_en_i  (crc_en),
    .wr_valid_o(wr_valid),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .slip_err_o(slip_err),
    .crc_err_o (crc_err)
  );

  typedef struct packed {
    logic        wr;
    logic        slip;
    logic        crc;
    logic [4:0]  addr;
    logic [15:0] data;
  } exp_t;

  // long division by x^8+x^2+x+1 over {hdr, 8'h00}
  function automatic logic [7:0] ref_crc(logic [23:0] h);
    logic [31:0] v = {h, 8'h00};
    for (int i = 31; i >= 8; i--)
      if (v[i]) v = v ^ (32'h107 << (i - 8));
    return v[7:0];
  endfunction

  function automatic exp_t model(logic [31:0] w, int nb, bit ce, logic [1:0] hw);
    exp_t e = '0;
    bit len_ok  = (nb == 32) || (nb == 24 && !ce);
    bit slip_ok = w[31] != w[30];
    bit crc_ok  = !ce || (ref_crc(w[31:8]) == w[7:0]);
    if (len_ok) begin
      if (!slip_ok)          e.slip = 1'b1;
      else if (!crc_ok)      e.crc  = 1'b1;
      else if (w[30:29] == hw) e.wr = 1'b1;
    end
    e.addr = w[28:24];
    e.data = w[23:8];
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bits(logic [31:0] w, int nb, bit idle_hi);
    logic [31:0] t = w;
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 32) ? t[31] : 1'b0;
      t   = t << 1;
      if (!idle_hi) begin
        sclk = 1'b1; repeat (3) @(negedge clk);
        sclk = 1'b0; repeat (3) @(negedge clk);
      end else begin
        repeat (3) @(negedge clk);
        sclk = 1'b0; repeat (3) @(negedge clk);
        sclk = 1'b1;
      end
    end
  endtask

  task automatic run_frame(logic [31:0] w, int nb, bit idle_hi, string req);
    exp_t e = model(w, nb, crc_en, dev_addr);
    @(negedge clk);
    sclk = idle_hi;
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    send_bits(w, nb, idle_hi);
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({wr_valid, slip_err, crc_err} == {e.wr, e.slip, e.crc}, req, "verdict",
          {29'd0, wr_valid, slip_err, crc_err}, {29'd0, e.wr, e.slip, e.crc});
    if (e.wr)
      check({wr_addr, wr_data} == {e.addr, e.data}, req, "addr/data",
            {11'd0, wr_addr, wr_data}, {11'd0, e.addr, e.data});
    @(negedge clk);
    check({wr_valid, slip_err, crc_err} == 3'b000, "R10", "pulse end",
          {29'd0, wr_valid, slip_err, crc_err}, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1 reset values
    check({wr_valid, slip_err, crc_err, wr_addr, wr_data} == '0, "R1", "reset",
          {8'd0, wr_valid, slip_err, crc_err, wr_addr, wr_data}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({wr_valid, slip_err, crc_err, wr_addr, wr_data} == '0, "R1", "idle",
          {8'd0, wr_valid, slip_err, crc_err, wr_addr, wr_data}, 32'd0);

    // R3 known-good frames, clock idle low
    run_frame(32'h8815FAA4, 32, 1'b0, "R3");
    run_frame(32'h88AF5131, 32, 1'b0, "R3");
    run_frame(32'h93001478, 32, 1'b0, "R3");
    run_frame(32'h8000000B, 32, 1'b0, "R3");
    run_frame(32'h88FCBA9D, 32, 1'b0, "R3");
    // R2 clock idle high
    run_frame(32'h942000AC, 32, 1'b1, "R2");
    // R4 slip bit broken, then slip and crc both broken
    run_frame(32'h0815FAA4, 32, 1'b0, "R4");
    run_frame(32'hC815FA00, 32, 1'b0, "R4");
    // R6 crc mismatch
    run_frame(32'h8815FAA5, 32, 1'b0, "R6");
    // R5 address filter
    dev_addr = 2'b01;
    run_frame(32'h8815FAA4, 32, 1'b0, "R5");
    run_frame({24'hA815FA, ref_crc(24'hA815FA)}, 32, 1'b0, "R5");
    run_frame({24'hA815FA, ~ref_crc(24'hA815FA)}, 32, 1'b0, "R6");
    dev_addr = 2'b00;
    // R8 length errors with crc on
    run_frame(32'h8815FAA4, 24, 1'b0, "R8");
    run_frame(32'h8815FAA4, 31, 1'b0, "R8");
    run_frame(32'h8815FAA4, 33, 1'b0, "R8");
    // R7 crc disabled
    crc_en = 1'b0;
    run_frame(32'h8815FA00, 24, 1'b0, "R7");
    run_frame(32'h8A12345F, 32, 1'b0, "R7");
    run_frame(32'h8A123400, 25, 1'b0, "R8");
    crc_en = 1'b1;

    // R9 clock activity while deselected
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      sdi = 1'b1; sclk = 1'b1; repeat (3) @(negedge clk);
      sclk = 1'b0; repeat (3) @(negedge clk);
    end
    check({wr_valid, slip_err, crc_err} == 3'b000, "R9", "no pulse while deselected",
          {29'd0, wr_valid, slip_err, crc_err}, 32'd0);
    run_frame(32'h88AF5131, 32, 1'b0, "R9");

    // random mix against the model
    for (int n = 0; n < 40; n++) begin
      logic [23:0] h = 24'($urandom);
      logic [31:0] w;
      int r = int'($urandom % 10);
      int nb = 32;
      dev_addr = 2'($urandom);
      crc_en   = ($urandom % 4) != 0;
      h[23] = ~h[22];
      if (r == 0) h[23] = h[22];
      if (r < 7) h[22:21] = dev_addr;
      w = {h, ref_crc(h)};
      if (r == 1) w[7:0] = w[7:0] ^ 8'h10;
      if (r == 2) nb = crc_en ? 31 : 24;
      run_frame(w, nb, bit'($urandom % 2), "R3/R6 random");
    end

    done = 1'b1;
    report();
  end
endmodule